// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Complete

This block collects a vector of interrupt sources and routes them to a small number of target contexts, each of which is typically a processor privilege level. Every source has a priority of its own. Every context has its own set of enable bits, a priority threshold and a single claim/complete register. A context's request line is raised while at least one source qualifies for it. A source qualifies when it is pending, enabled for that context, and its priority is strictly above that context's threshold.

Software serves a request in two steps. It first reads the context's claim register, which returns the best qualifying source and takes that source out of the pending set. After handling the source, it writes the same number back to the same register. A claimed source stays quiet until that completion write arrives, so a handler may keep claiming until it reads 0. Source numbers below the parameter `EDGE_FROM` are level-high sources. Numbers from `EDGE_FROM` upward are rising-edge sources, and an edge that arrives while such a source is claimed is kept and presented again after completion.

Register access uses a simple single-cycle port with byte addresses. A read's data appears on `bus_rdata` after the clock edge that accepts the read, and any claim triggered by that read takes effect at the same edge.

Top module: `plic_core`

## Requirements
- R1: After reset, every priority, enable word and threshold reads 0, every request output is low, and a claim read returns 0.
- R2: Source n has a priority register at byte address 4·n. Only bits [2:0] are stored, and the upper bits read as 0. Source 0's priority always reads 0 and ignores writes.
- R3: Context c has an enable word at 0x2000 + 0x80·c, in which bit n enables source n. Bit 0 always reads 0.
- R4: Context c's threshold is at 0x200000 + 0x1000·c, and only bits [2:0] are stored. Request line c is high only while an enabled, pending source has a priority strictly greater than that threshold, so a priority equal to the threshold gives no request.
- R5: A threshold of 7 blocks every source for that context, and a priority of 0 masks a source for every context.
- R6: A read of the claim register at 0x200004 + 0x1000·c returns the qualifying source with the highest priority. When priorities tie, the lowest source number wins.
- R7: A claim read removes the returned source from the pending set, and that source is not presented again before completion. A claim read with nothing qualifying returns 0.
- R8: A write to the claim register completes source n only if n is currently claimed by that same context. A write of an unclaimed number, of a number claimed by another context, or of an out-of-range number has no effect.
- R9: A level source that is still high when it is completed becomes pending again and can be claimed again.
- R10: An edge source becomes pending once per rising edge. A level held high after the source is claimed and completed does not make it pending again. A rising edge during the claimed period is held and presented after completion.
- R11: A read of any address that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt source lines; bit 0 is unused |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | NUM_CTX | Request line per context |

## Verification
Two things can land on the same source in the same cycle: a completion write that releases it, and a fresh trigger for it, either a level still held high or a new rising edge during the claimed period. The bench provokes both cases. It completes a level source that is still high, and it pulses an edge source while that source is claimed. It then checks that the source comes back exactly once, one cycle after the release, and not before it. It also sends completions from the wrong context and with out-of-range numbers in the same scenario, then shows through later claim reads that those writes left the claimed state untouched.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;
    localparam int          MAX_CTX    = 16;

    typedef enum logic [2:0] {
        K_NONE,
        K_PRIO,
        K_EN,
        K_THR,
        K_CLAIM
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [3:0] ctx;
        logic [7:0] idx;
    } acc_t;

    function automatic acc_t decode_addr(input logic [31:0] a, input int nsrc, input int nctx);
        acc_t r;
        r.kind = K_NONE;
        r.ctx  = '0;
        r.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 32'(4 * nsrc)) begin
                r.kind = K_PRIO;
                r.idx  = a[9:2];
            end
            for (int c = 0; c < MAX_CTX; c++) begin
                if (c < nctx) begin
                    if (a == EN_BASE + EN_STRIDE * 32'(c)) begin
                        r.kind = K_EN;
                        r.ctx  = 4'(c);
                    end
                    if (a == CTX_BASE + CTX_STRIDE * 32'(c)) begin
                        r.kind = K_THR;
                        r.ctx  = 4'(c);
                    end
                    if (a == CTX_BASE + CTX_STRIDE * 32'(c) + CLAIM_OFS) begin
                        r.kind = K_CLAIM;
                        r.ctx  = 4'(c);
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic claim_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);

    logic pend_q, busy_q, trig;

    generate
        if (IS_EDGE) begin : g_edge
            logic src_q, held_q, rise;
            assign rise = src_i & ~src_q;
            assign trig = rise | held_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    src_q  <= 1'b0;
                    held_q <= 1'b0;
                end else begin
                    src_q <= src_i;
                    if (rise && busy_q)
                        held_q <= 1'b1;
                    else if (!pend_q && !busy_q && trig)
                        held_q <= 1'b0;
                end
            end
        end else begin : g_level
            assign trig = src_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (claim_i)
                pend_q <= 1'b0;
            else if (!pend_q && !busy_q && trig)
                pend_q <= 1'b1;

            if (claim_i)
                busy_q <= 1'b1;
            else if (done_i)
                busy_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;
    assign busy_o = busy_q;

endmodule

// File: rtl/plic_ctx_arb.sv
module plic_ctx_arb #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [ID_W-1:0]                win_id_o,
    output logic                           irq_o
);

    logic [PRIO_W-1:0] best_p;
    logic [ID_W-1:0]   best_id;

    always_comb begin
        best_p  = '0;
        best_id = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] > best_p)) begin
                best_p  = prio_i[i];
                best_id = ID_W'(i);
            end
        end
    end

    assign win_id_o = best_id;
    assign irq_o    = (best_id != '0);

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int NUM_SRC   = 32,
    parameter int NUM_CTX   = 2,
    parameter int PRIO_W    = 3,
    parameter int EDGE_FROM = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [31:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int ID_W  = $clog2(NUM_SRC);
    localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
    logic [NUM_SRC-1:0][CTX_W-1:0]   owner_q;
    logic [NUM_CTX-1:0][ID_W-1:0]    win_id;

    logic [NUM_SRC-1:0] pend_vec, busy_vec, claim_vec, done_vec;

    acc_t             acc;
    logic [CTX_W-1:0] cidx;
    logic [ID_W-1:0]  pidx, claim_id;
    logic             claim_go, done_go;
    logic [31:0]      rd_mux;

    assign acc      = decode_addr(bus_addr, NUM_SRC, NUM_CTX);
    assign cidx     = CTX_W'(acc.ctx);
    assign pidx     = ID_W'(acc.idx);
    assign claim_go = bus_en && !bus_we && (acc.kind == K_CLAIM);
    assign done_go  = bus_en &&  bus_we && (acc.kind == K_CLAIM);
    assign claim_id = win_id[cidx];

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign claim_vec[i] = claim_go && (i != 0) && (claim_id == ID_W'(i));
            assign done_vec[i]  = done_go && (bus_wdata == 32'(i)) && busy_vec[i]
                                  && (owner_q[i] == cidx);
            if (i == 0) begin : g_none
                assign pend_vec[i] = 1'b0;
                assign busy_vec[i] = 1'b0;
            end else begin : g_gw
                plic_gateway #(
                    .IS_EDGE(i >= EDGE_FROM)
                ) u_gw (
                    .clk    (clk),
                    .rst    (rst),
                    .src_i  (src_i[i]),
                    .claim_i(claim_vec[i]),
                    .done_i (done_vec[i]),
                    .pend_o (pend_vec[i]),
                    .busy_o (busy_vec[i])
                );
            end
        end

        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            plic_ctx_arb #(
                .NUM_SRC(NUM_SRC),
                .PRIO_W (PRIO_W),
                .ID_W   (ID_W)
            ) u_arb (
                .pend_i  (pend_vec),
                .en_i    (en_q[c]),
                .prio_i  (prio_q),
                .thr_i   (thr_q[c]),
                .win_id_o(win_id[c]),
                .irq_o   (irq_o[c])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        case (acc.kind)
            K_PRIO:  rd_mux = 32'(prio_q[pidx]);
            K_EN:    rd_mux = 32'(en_q[cidx]);
            K_THR:   rd_mux = 32'(thr_q[cidx]);
            K_CLAIM: rd_mux = 32'(claim_id);
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q    <= '0;
            en_q      <= '0;
            thr_q     <= '0;
            owner_q   <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_en && bus_we) begin
                case (acc.kind)
                    K_PRIO:  if (pidx != '0) prio_q[pidx] <= bus_wdata[PRIO_W-1:0];
                    K_EN:    en_q[cidx]  <= bus_wdata[NUM_SRC-1:0] & ~NUM_SRC'(1);
                    K_THR:   thr_q[cidx] <= bus_wdata[PRIO_W-1:0];
                    default: ;
                endcase
            end
            if (claim_go && (claim_id != '0))
                owner_q[claim_id] <= cidx;
            if (bus_en && !bus_we)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/plic_core_checker.sv
module plic_core_checker
    import plic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_en,
    input logic               bus_we,
    input logic [31:0]        bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CTX-1:0] irq_o,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [NUM_SRC-1:0] busy_vec
);

    localparam int ID_W = $clog2(NUM_SRC);

    acc_t chk_acc;
    logic claim_rd, unmapped_rd;

    assign chk_acc     = decode_addr(bus_addr, NUM_SRC, NUM_CTX);
    assign claim_rd    = bus_en && !bus_we && (chk_acc.kind == K_CLAIM);
    assign unmapped_rd = bus_en && !bus_we && (chk_acc.kind == K_NONE);

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_o == '0) && (pend_vec == '0) && (busy_vec == '0));

    // R4: a request line needs some pending source
    p_irq_needs_pend_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_o != '0) |-> (pend_vec != '0));

    // R7: a returned source is claimed and no longer pending
    p_claim_takes_r7: assert property (@(posedge clk) disable iff (rst)
        claim_rd |=> (bus_rdata == '0) ||
                     (!pend_vec[bus_rdata[ID_W-1:0]] && busy_vec[bus_rdata[ID_W-1:0]]));

    // R7: pending and claimed never overlap
    p_pend_busy_excl_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_vec & busy_vec) == '0);

    // R8: a claim is released only by a bus write
    p_release_by_write_r8: assert property (@(posedge clk) disable iff (rst)
        (($past(busy_vec) & ~busy_vec) != '0) |-> $past(bus_en && bus_we));

    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
        unmapped_rd |=> (bus_rdata == '0));

endmodule

bind plic_core plic_core_checker #(
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .pend_vec (pend_vec),
    .busy_vec (busy_vec)
);

// File: tb/test_plic_core.sv
module test_plic_core;

    localparam int NSRC    = 32;
    localparam int NCTX    = 2;
    localparam int CLK_PER = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic            bus_en = 1'b0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCTX-1:0] irq_o;

    int checks = 0;
    int failures = 0;
    logic finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    plic_core #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(3), .EDGE_FROM(16)) i_plic_core (
        .clk(clk), .rst(rst), .src_i(src_i),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    function automatic logic [31:0] a_prio(int id);  return 32'(4 * id); endfunction
    function automatic logic [31:0] a_en(int c);     return 32'h2000 + 32'(c * 32'h80); endfunction
    function automatic logic [31:0] a_thr(int c);    return 32'h20_0000 + 32'(c * 32'h1000); endfunction
    function automatic logic [31:0] a_claim(int c);  return 32'h20_0004 + 32'(c * 32'h1000); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq_o), 0);
        rd(a_prio(5), d);   check("R1 prio", d, 0);
        rd(a_en(1), d);     check("R1 en", d, 0);
        rd(a_thr(1), d);    check("R1 thr", d, 0);
        rd(a_claim(0), d);  check("R1 claim", d, 0);
        rd(32'h1000, d);    check("R11 hole", d, 0);
        rd(32'h20_0008, d); check("R11 ctx gap", d, 0);
        rd(32'h20_2000, d); check("R11 ctx2", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(a_prio(3), 32'hFFFF_FFFD); rd(a_prio(3), d); check("R2 low bits", d, 5);
        wr(a_prio(0), 7);             rd(a_prio(0), d); check("R2 id0", d, 0);
        wr(a_en(0), 32'hFFFF_FFFF);   rd(a_en(0), d);   check("R3 en bit0", d, 32'hFFFF_FFFE);
        rd(a_en(1), d);                                 check("R3 en ctx1", d, 0);
        wr(a_thr(1), 32'h0000_00FF);  rd(a_thr(1), d);  check("R4 thr bits", d, 7);
        wr(a_prio(3), 0); wr(a_en(0), 0); wr(a_thr(1), 0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        wr(a_prio(3), 2); wr(a_en(0), 32'h8); wr(a_thr(0), 2);
        src_i[3] = 1'b1; idle(2);
        check("R4 equal blocks", 32'(irq_o), 0);
        wr(a_thr(0), 1);
        check("R4 above", 32'(irq_o), 1);
        wr(a_prio(3), 7); wr(a_thr(0), 7);
        check("R5 thr7", 32'(irq_o), 0);
        wr(a_prio(3), 0); wr(a_thr(0), 0);
        check("R5 prio0", 32'(irq_o), 0);
        wr(a_prio(3), 1);
        check("R4 prio1 thr0", 32'(irq_o), 1);
        rd(a_claim(0), d); check("R6 single", d, 3);
        src_i[3] = 1'b0;
        wr(a_claim(0), 3); idle(2);
        rd(a_claim(0), d); check("R7 empty", d, 0);
        wr(a_prio(3), 0); wr(a_en(0), 0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        wr(a_prio(2), 3); wr(a_prio(5), 5); wr(a_prio(7), 5);
        wr(a_en(0), (32'h1 << 2) | (32'h1 << 5) | (32'h1 << 7));
        src_i[2] = 1'b1; src_i[5] = 1'b1; src_i[7] = 1'b1; idle(2);
        rd(a_claim(0), d); check("R6 tie low id", d, 5);
        rd(a_claim(0), d); check("R6 next tie", d, 7);
        rd(a_claim(0), d); check("R6 lower prio", d, 2);
        check("R7 all claimed irq", 32'(irq_o), 0);
        rd(a_claim(0), d); check("R7 none left", d, 0);
        wr(a_claim(1), 5); idle(2);
        rd(a_claim(0), d); check("R8 wrong ctx", d, 0);
        wr(a_claim(0), 40); wr(a_claim(0), 3); idle(2);
        rd(a_claim(0), d); check("R8 bad id", d, 0);
        wr(a_claim(0), 5); idle(1);
        check("R9 repend irq", 32'(irq_o), 1);
        rd(a_claim(0), d); check("R9 reclaim", d, 5);
        src_i[2] = 1'b0; src_i[5] = 1'b0; src_i[7] = 1'b0;
        wr(a_claim(0), 5); wr(a_claim(0), 7); wr(a_claim(0), 2); idle(2);
        rd(a_claim(0), d); check("R9 low done", d, 0);
        wr(a_en(0), 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(a_prio(20), 4); wr(a_en(1), 32'h1 << 20); wr(a_thr(1), 0);
        src_i[20] = 1'b1; idle(1);
        check("R10 edge irq", 32'(irq_o), 2);
        rd(a_claim(1), d); check("R10 claim", d, 20);
        idle(2);
        rd(a_claim(1), d); check("R10 held level", d, 0);
        wr(a_claim(1), 20); idle(2);
        check("R10 no repend", 32'(irq_o), 0);
        src_i[20] = 1'b0; idle(1); src_i[20] = 1'b1; idle(1);
        rd(a_claim(1), d); check("R10 second edge", d, 20);
        src_i[20] = 1'b0; idle(1); src_i[20] = 1'b1; idle(2);
        check("R10 edge held", 32'(irq_o), 0);
        rd(a_claim(1), d); check("R7 busy quiet", d, 0);
        wr(a_claim(1), 20); idle(1);
        check("R10 replay irq", 32'(irq_o), 2);
        rd(a_claim(1), d); check("R10 replay id", d, 20);
        wr(a_claim(1), 20); idle(2);
        check("R10 once only", 32'(irq_o), 0);
        src_i[20] = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_threshold();
        t_arb();
        t_edge();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule